// File: doc/BRIEF.md
# Edge-Activated DMA Request Acceptor

This block sits between an external, active-low transfer-request pin and the activation logic of one DMA channel running in edge-triggered mode. It turns a falling edge on the pin into a single held request. The pin is first brought into the clock domain through a small synchronizer, and one sample is taken on each rising clock edge. When acceptance is open and a low sample arrives, the block raises `req_pending` and holds it until the controller signals that activation has begun.

After activation the block does not accept again at once. It waits until it has sampled the pin high, which closes the edge, and until the DMA write cycle in progress has ended. Only then does it reopen acceptance. A fixed guard interval follows reopening before a new request can register, so one low pulse can never count twice. A transfer-done indication or a reset puts the block back into a closed idle state, and only a fresh channel-enable pulse opens it again. That pulse is honoured only while the channel's request source is set to edge activation.

Top module: `dreq_edge_acceptor`

## Requirements
- R1: After reset `req_pending` is 0 and acceptance is closed. A low pin raises no request until an accepted enable pulse.
- R2: A `ch_enable_pulse` sampled high on edge k, while idle with `edge_sel`=1, opens acceptance. The pin is sampled from edge k+1 onward. A low level present at `req_in_n` at edge j while acceptance is open raises `req_pending` after edge j+2, which is the synchronizer latency.
- R3: Once raised, `req_pending` stays 1 whatever the pin does, until an activation strobe or transfer-done is sampled.
- R4: An `act_strobe` sampled high while `req_pending` is 1 clears it at that edge. An activation strobe sampled while acceptance is open but no request is held has no effect, and a later low still raises the request.
- R5: After activation, acceptance reopens only once a high pin sample has been taken. If that high sample came before the write cycle ended, reopening happens at the edge where `wr_end_strobe` is sampled high.
- R6: If the write cycle ends before any high sample, reopening happens at the edge where the first high sample is taken.
- R7: After the reopening edge r, `req_pending` cannot rise before edge r+MIN_GAP (default 2). With the synchronized pin already low, it rises exactly at edge r+MIN_GAP.
- R8: If the pin stays low after activation, acceptance never reopens and `req_pending` stays 0, even after the write cycle ends.
- R9: `xfer_done` sampled high returns the block to idle from any state and clears `req_pending`. It takes priority over a simultaneous activation strobe. Activation and write-end strobes sampled while idle have no effect.
- R10: While `edge_sel` is 0, `ch_enable_pulse` is ignored and the block stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_in_n | input | 1 | External transfer request, active low, asynchronous |
| ch_enable_pulse | input | 1 | One-cycle pulse at the end of the control write that enables the channel |
| edge_sel | input | 1 | Request source select: 1 = edge-activated pin request |
| act_strobe | input | 1 | Controller begins activation for this channel |
| wr_end_strobe | input | 1 | The DMA write cycle of the current transfer has ended |
| xfer_done | input | 1 | The whole transfer is complete |
| req_pending | output | 1 | A request is held and waiting for activation |

## Verification
On every cycle the assertions check four things: a held request survives until activation or completion, activation and completion clear it on the next edge, a rise of the request always follows a low synchronized sample, and no rise comes sooner than the guard interval after a reopening. An enable pulse while edge mode is off is also checked to leave the block idle. The bench scenarios are needed to show the exact edge on which acceptance starts after enable, and the sync latency. They also show the two orderings of high sample versus write end, the permanent block when the pin never returns high, and recovery after completion with a new enable pulse.

// File: rtl/dreq_pkg.sv
package dreq_pkg;

  typedef enum logic [2:0] {
    ACC_IDLE    = 3'd0,  // closed, waiting for channel enable
    ACC_OPEN    = 3'd1,  // looking for a low sample
    ACC_HELD    = 3'd2,  // request pending
    ACC_HICHK   = 3'd3,  // after activation: neither high nor write end seen
    ACC_WAIT_WR = 3'd4,  // high seen, write cycle still running
    ACC_WAIT_HI = 3'd5,  // write cycle over, high not yet seen
    ACC_GUARD   = 3'd6   // reopened, guard interval running
  } acc_state_e;

endpackage

// File: rtl/dreq_pin_sync.sv
module dreq_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic pin_n_sync
);

  logic [STAGES-1:0] stage_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= 1'b1;
          else        stage_q[0] <= pin_n;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= 1'b1;
          else        stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign pin_n_sync = stage_q[STAGES-1];

endmodule

// File: rtl/dreq_guard_timer.sv
module dreq_guard_timer #(
  parameter int MIN_GAP = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic expired
);

  localparam int CW       = (MIN_GAP > 2) ? $clog2(MIN_GAP) : 1;
  localparam int LOAD_VAL = (MIN_GAP > 2) ? (MIN_GAP - 2) : 0;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (start) begin
      cnt_en = 1'b1;
      cnt_d  = CW'(LOAD_VAL);
    end else if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/dreq_accept_fsm.sv
module dreq_accept_fsm
  import dreq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_low,
  input  logic       chan_en,
  input  logic       edge_sel,
  input  logic       act,
  input  logic       wr_end,
  input  logic       done,
  input  logic       guard_expired,
  output acc_state_e state,
  output logic       guard_start,
  output logic       pending
);

  acc_state_e state_q;
  acc_state_e state_d;

  always_comb begin
    state_d     = state_q;
    guard_start = 1'b0;
    if (done) begin
      state_d = ACC_IDLE;
    end else begin
      unique case (state_q)
        ACC_IDLE:    if (chan_en && edge_sel) state_d = ACC_OPEN;
        ACC_OPEN:    if (pin_low) state_d = ACC_HELD;
        ACC_HELD:    if (act) state_d = ACC_HICHK;
        ACC_HICHK: begin
          if (!pin_low && wr_end) begin
            state_d     = ACC_GUARD;
            guard_start = 1'b1;
          end else if (!pin_low) begin
            state_d = ACC_WAIT_WR;
          end else if (wr_end) begin
            state_d = ACC_WAIT_HI;
          end
        end
        ACC_WAIT_WR: begin
          if (wr_end) begin
            state_d     = ACC_GUARD;
            guard_start = 1'b1;
          end
        end
        ACC_WAIT_HI: begin
          if (!pin_low) begin
            state_d     = ACC_GUARD;
            guard_start = 1'b1;
          end
        end
        ACC_GUARD:   if (guard_expired) state_d = ACC_OPEN;
        default:     state_d = ACC_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ACC_IDLE;
    else        state_q <= state_d;
  end

  assign state   = state_q;
  assign pending = (state_q == ACC_HELD);

endmodule

// File: rtl/dreq_edge_acceptor.sv
module dreq_edge_acceptor #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_GAP     = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_in_n,
  input  logic ch_enable_pulse,
  input  logic edge_sel,
  input  logic act_strobe,
  input  logic wr_end_strobe,
  input  logic xfer_done,
  output logic req_pending
);

  import dreq_pkg::*;

  logic       pin_n_sync;
  logic       guard_start;
  logic       guard_expired;
  acc_state_e fsm_state;

  dreq_pin_sync #(
    .STAGES(SYNC_STAGES)
  ) sync_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_n     (req_in_n),
    .pin_n_sync(pin_n_sync)
  );

  dreq_guard_timer #(
    .MIN_GAP(MIN_GAP)
  ) guard_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (guard_start),
    .expired(guard_expired)
  );

  dreq_accept_fsm fsm_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .pin_low      (!pin_n_sync),
    .chan_en      (ch_enable_pulse),
    .edge_sel     (edge_sel),
    .act          (act_strobe),
    .wr_end       (wr_end_strobe),
    .done         (xfer_done),
    .guard_expired(guard_expired),
    .state        (fsm_state),
    .guard_start  (guard_start),
    .pending      (req_pending)
  );

endmodule

// File: rtl/dreq_edge_acceptor_chk.sv
module dreq_edge_acceptor_chk
  import dreq_pkg::*;
#(
  parameter int MIN_GAP = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ch_enable_pulse,
  input logic       edge_sel,
  input logic       act_strobe,
  input logic       xfer_done,
  input logic       req_pending,
  input logic       pin_n_sync,
  input logic       guard_start,
  input acc_state_e fsm_state
);

  localparam int SW = $clog2(MIN_GAP + 1);

  // cycles since the last reopening, saturating at MIN_GAP
  logic [SW-1:0] since_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    since_q <= SW'(MIN_GAP);
    else if (guard_start)          since_q <= SW'(1);
    else if (since_q != SW'(MIN_GAP)) since_q <= since_q + 1'b1;
  end

  // R3: a held request survives until activation or completion
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_pending && !act_strobe && !xfer_done) |=> req_pending);

  // R4: activation clears the held request
  p_clear_on_act_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_pending && act_strobe) |=> !req_pending);

  // R9: completion forces the request low
  p_done_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !req_pending);

  // R2: a new request only follows a low synchronized sample
  p_rise_needs_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_pending) |-> !$past(pin_n_sync));

  // R7: no request sooner than the guard interval after reopening
  p_guard_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_pending) |-> ($past(since_q) >= SW'(MIN_GAP)));

  // R10: enable ignored while edge mode is off
  p_enable_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_state == ACC_IDLE && !edge_sel && !xfer_done) |=> (fsm_state == ACC_IDLE));

endmodule

bind dreq_edge_acceptor dreq_edge_acceptor_chk #(
  .MIN_GAP(MIN_GAP)
) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .ch_enable_pulse(ch_enable_pulse),
  .edge_sel       (edge_sel),
  .act_strobe     (act_strobe),
  .xfer_done      (xfer_done),
  .req_pending    (req_pending),
  .pin_n_sync     (pin_n_sync),
  .guard_start    (guard_start),
  .fsm_state      (fsm_state)
);

// File: tb/dreq_edge_acceptor_tb_top.sv
`timescale 1ns/1ps
module dreq_edge_acceptor_tb_top;

  logic clk;
  logic rst_n;
  logic req_in_n;
  logic ch_enable_pulse;
  logic edge_sel;
  logic act_strobe;
  logic wr_end_strobe;
  logic xfer_done;
  logic req_pending;

  int n_checks;
  int n_fails;
  bit finished;

  typedef struct {
    logic  exp;
    string tag;
  } sb_item_t;

  sb_item_t sb_q[$];

  dreq_edge_acceptor dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_in_n       (req_in_n),
    .ch_enable_pulse(ch_enable_pulse),
    .edge_sel       (edge_sel),
    .act_strobe     (act_strobe),
    .wr_end_strobe  (wr_end_strobe),
    .xfer_done      (xfer_done),
    .req_pending    (req_pending)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // driver: drive one cycle of inputs and queue the expected output after the next edge
  task automatic cyc(input logic pin, input logic en, input logic act,
                     input logic wr, input logic dn, input logic exp,
                     input string tag);
    sb_item_t it;
    @(negedge clk);
    req_in_n        = pin;
    ch_enable_pulse = en;
    act_strobe      = act;
    wr_end_strobe   = wr;
    xfer_done       = dn;
    it.exp = exp;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  // monitor: compare after each edge
  always @(posedge clk) begin : mon
    sb_item_t got;
    if (sb_q.size() != 0) begin
      got = sb_q.pop_front();
      #2;
      n_checks++;
      if (req_pending !== got.exp) begin
        n_fails++;
        $display("FAIL %s: req_pending=%b expected %b at %0t",
                 got.tag, req_pending, got.exp, $time);
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_fails++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin : stim
    n_checks = 0;
    n_fails  = 0;
    finished = 0;
    rst_n = 1'b0;
    req_in_n = 1'b1;
    ch_enable_pulse = 1'b0;
    edge_sel = 1'b1;
    act_strobe = 1'b0;
    wr_end_strobe = 1'b0;
    xfer_done = 1'b0;
    repeat (3) @(negedge clk);
    n_checks++;
    if (req_pending !== 1'b0) begin
      n_fails++;
      $display("FAIL R1: req_pending=%b expected 0 in reset", req_pending);
    end
    rst_n = 1'b1;

    // R1: idle after reset
    cyc(1, 0, 0, 0, 0, 0, "R1");
    cyc(0, 0, 0, 0, 0, 0, "R1");
    cyc(0, 0, 0, 0, 0, 0, "R1");
    cyc(0, 0, 0, 0, 0, 0, "R1");

    // R10: enable ignored with edge mode off
    edge_sel = 1'b0;
    cyc(0, 1, 0, 0, 0, 0, "R10");
    cyc(0, 0, 0, 0, 0, 0, "R10");
    cyc(0, 0, 0, 0, 0, 0, "R10");
    edge_sel = 1'b1;
    cyc(0, 0, 0, 0, 0, 0, "R10");
    cyc(0, 0, 0, 0, 0, 0, "R1");

    // R2: enable with pin already low, sampled from the next edge
    cyc(0, 1, 0, 0, 0, 0, "R2");
    cyc(0, 0, 0, 0, 0, 1, "R2");

    // R3: held regardless of pin
    cyc(1, 0, 0, 0, 0, 1, "R3");
    cyc(1, 0, 0, 0, 0, 1, "R3");
    cyc(1, 0, 0, 0, 0, 1, "R3");
    cyc(0, 0, 0, 0, 0, 1, "R3");
    cyc(1, 0, 0, 0, 0, 1, "R3");
    cyc(1, 0, 0, 0, 0, 1, "R3");

    // R4 then R5: high seen before write end
    cyc(1, 0, 1, 0, 0, 0, "R4");
    cyc(1, 0, 0, 0, 0, 0, "R5");
    cyc(1, 0, 0, 0, 0, 0, "R5");
    cyc(0, 0, 0, 0, 0, 0, "R5");
    cyc(0, 0, 0, 1, 0, 0, "R5");
    cyc(0, 0, 0, 0, 0, 0, "R7");
    cyc(0, 0, 0, 0, 0, 1, "R7");

    // R6: write end before high
    cyc(0, 0, 1, 0, 0, 0, "R4");
    cyc(0, 0, 0, 1, 0, 0, "R6");
    cyc(1, 0, 0, 0, 0, 0, "R6");
    cyc(1, 0, 0, 0, 0, 0, "R6");
    cyc(1, 0, 0, 0, 0, 0, "R6");
    cyc(0, 0, 0, 0, 0, 0, "R7");
    cyc(0, 0, 0, 0, 0, 0, "R2");
    cyc(0, 0, 0, 0, 0, 1, "R2");

    // R8: pin never returns high
    cyc(0, 0, 1, 0, 0, 0, "R4");
    cyc(0, 0, 0, 1, 0, 0, "R8");
    cyc(0, 0, 0, 0, 0, 0, "R8");
    cyc(0, 0, 0, 0, 0, 0, "R8");
    cyc(0, 0, 0, 0, 0, 0, "R8");
    cyc(0, 0, 0, 0, 0, 0, "R8");

    // R9: completion, strobes ignored while idle, re-enable
    cyc(1, 0, 0, 0, 1, 0, "R9");
    cyc(0, 0, 1, 1, 0, 0, "R9");
    cyc(0, 0, 1, 1, 0, 0, "R9");
    cyc(0, 0, 0, 0, 0, 0, "R9");
    cyc(0, 0, 0, 0, 0, 0, "R9");
    cyc(0, 1, 0, 0, 0, 0, "R9");
    cyc(0, 0, 0, 0, 0, 1, "R9");

    // R4: activation while open and not held is ignored
    cyc(1, 0, 0, 0, 1, 0, "R9");
    cyc(1, 1, 0, 0, 0, 0, "R2");
    cyc(1, 0, 1, 0, 0, 0, "R4");
    cyc(0, 0, 0, 0, 0, 0, "R4");
    cyc(0, 0, 0, 0, 0, 0, "R4");
    cyc(0, 0, 0, 0, 0, 1, "R4");

    // R9: completion wins over activation
    cyc(0, 0, 1, 0, 1, 0, "R9");
    cyc(0, 0, 0, 0, 0, 0, "R9");
    cyc(0, 0, 0, 0, 0, 0, "R9");

    @(negedge clk);
    req_in_n = 1'b1;
    act_strobe = 1'b0;
    xfer_done = 1'b0;
    repeat (3) @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule